// File: doc/BRIEF.md
# Dual-Port Memory with Independent Port Widths

This block is a synchronous two-port memory holding 18,432 bits: 16,384 data bits and 2,048 parity bits. Each port sees the same bit array through its own width, chosen at build time from 1, 2, 4, 9, 18 or 36 bits. A port with a wide word and a port with a narrow word can therefore move data between bus widths with no extra logic. Widths of 9 and above carry one parity bit per data byte. Widths below 9 reach the data bits only.

Each port has an enable, a write enable, a synchronous output reset, an address, write data and a registered read output. A build-time code sets how each port's output behaves during its own write: it shows the new word, it shows the old contents, or it keeps its last value. Both ports run on one clock. A port can be confined to half of the array by holding its top address bit constant. With the other port held to the other half, the block acts as two independent single-port memories.

Top module: `dual_aspect_ram`

## Requirements
- R1: The port word width W is one of 1, 2, 4, 9, 18 or 36, and the port depth is 16384/W for W < 9 or 18432/W for W >= 9. For W >= 9, port word bits [W-1 : 8W/9] are parity bits and the lower 8W/9 bits are data bits.
- R2: Storage is organised as rows of 32 data bits plus 4 parity bits. Port address n with k slices per row (k = 36/W, or 32/W for W < 9) selects row n/k and slice n mod k. Slice 0 holds the least significant data bits and the least significant parity bits.
- R3: Reads are synchronous. The read word for an address is visible on the read output after the clock edge that captures that address.
- R4: Write mode code 0 (new data): on a write without output reset, the read output shows the word written in that cycle.
- R5: Write mode code 1 (old data): on a write without output reset, the read output shows what the location held before the write.
- R6: Write mode code 2 (hold): on a write without output reset, the read output keeps its previous value, and the write is still stored.
- R7: With the enable high, the output reset loads the port's configured reset value into the read output. A write in the same cycle is still stored.
- R8: With the enable low, the port writes nothing and ignores its output reset, and its read output holds its value.
- R9: A read on one port in the same cycle as a write to the same bits on the other port returns the old contents. The new contents are readable from the next cycle.
- R10: With the top address bit held at 0 on one port and at 1 on the other, the two ports reach disjoint halves of the array and do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| srst_a | input | 1 | Port A synchronous output reset |
| addr_a | input | A_AW | Port A address |
| wdata_a | input | A_W | Port A write word |
| rdata_a | output | A_W | Port A registered read word |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| srst_b | input | 1 | Port B synchronous output reset |
| addr_b | input | B_AW | Port B address |
| wdata_b | input | B_W | Port B write word |
| rdata_b | output | B_W | Port B registered read word |

## Verification
Two things can fall in one cycle: a write on one port, and a read of the same bits through the other port at a different width. The bench provokes this by having the 9-bit port write one byte of a row while the 18-bit port reads the word that covers that byte. It expects the old word that cycle and the merged word, with data and parity placed per the slice order, on the next read. A second overlap is an output reset and a write on the same port in one cycle. The bench judges it by the reset value on the output and by reading the written bits back through the other port.

// File: rtl/dual_aspect_ram.sv
module dual_aspect_ram #(
  parameter int ROWS = 512,
  parameter int A_W = 18,
  parameter int B_W = 9,
  parameter int A_MODE = 0,
  parameter int B_MODE = 1,
  parameter logic [A_W-1:0] A_RST_VAL = '0,
  parameter logic [B_W-1:0] B_RST_VAL = '0,
  localparam int RW = $clog2(ROWS),
  localparam int A_K = (A_W >= 9) ? 36 / A_W : 32 / A_W,
  localparam int B_K = (B_W >= 9) ? 36 / B_W : 32 / B_W,
  localparam int A_AW = RW + $clog2(A_K),
  localparam int B_AW = RW + $clog2(B_K)
) (
  input  logic            clk,
  input  logic            en_a,
  input  logic            we_a,
  input  logic            srst_a,
  input  logic [A_AW-1:0] addr_a,
  input  logic [A_W-1:0]  wdata_a,
  output logic [A_W-1:0]  rdata_a,
  input  logic            en_b,
  input  logic            we_b,
  input  logic            srst_b,
  input  logic [B_AW-1:0] addr_b,
  input  logic [B_W-1:0]  wdata_b,
  output logic [B_W-1:0]  rdata_b
);
  localparam int A_PD = (A_W >= 9) ? A_W / 9 : 0;
  localparam int B_PD = (B_W >= 9) ? B_W / 9 : 0;
  localparam int A_DD = A_W - A_PD;
  localparam int B_DD = B_W - B_PD;

  logic [35:0] mem [ROWS];

  logic [RW-1:0]   row_a, row_b;
  logic [A_AW-1:0] sl_a;
  logic [B_AW-1:0] sl_b;
  logic [5:0]      sh_a, sh_b;
  logic [35:0]     wm_a, wd_a, wm_b, wd_b;
  logic [35:0]     nxt_a, nxt_b, base_b;
  logic [A_W-1:0]  rd_a;
  logic [B_W-1:0]  rd_b;
  logic [A_DD-1:0] rdd_a;
  logic [B_DD-1:0] rdd_b;
  logic            wr_a, wr_b;

  assign row_a = addr_a[A_AW-1 -: RW];
  assign row_b = addr_b[B_AW-1 -: RW];
  assign sl_a  = addr_a & A_AW'(A_K - 1);
  assign sl_b  = addr_b & B_AW'(B_K - 1);
  assign sh_a  = 6'(int'(sl_a) * A_DD);
  assign sh_b  = 6'(int'(sl_b) * B_DD);
  assign wr_a  = en_a & we_a;
  assign wr_b  = en_b & we_b;

  assign rdd_a = A_DD'(mem[row_a][31:0] >> sh_a);
  assign rdd_b = B_DD'(mem[row_b][31:0] >> sh_b);
  assign wm_a[31:0] = 32'({A_DD{1'b1}}) << sh_a;
  assign wd_a[31:0] = 32'(wdata_a[A_DD-1:0]) << sh_a;
  assign wm_b[31:0] = 32'({B_DD{1'b1}}) << sh_b;
  assign wd_b[31:0] = 32'(wdata_b[B_DD-1:0]) << sh_b;

  if (A_PD > 0) begin : g_par_a
    logic [2:0] psh;
    assign psh = 3'(int'(sl_a) * A_PD);
    assign rd_a = {A_PD'(mem[row_a][35:32] >> psh), rdd_a};
    assign wm_a[35:32] = 4'({A_PD{1'b1}}) << psh;
    assign wd_a[35:32] = 4'(wdata_a[A_W-1:A_DD]) << psh;
  end else begin : g_nopar_a
    assign rd_a = rdd_a;
    assign wm_a[35:32] = '0;
    assign wd_a[35:32] = '0;
  end

  if (B_PD > 0) begin : g_par_b
    logic [2:0] psh;
    assign psh = 3'(int'(sl_b) * B_PD);
    assign rd_b = {B_PD'(mem[row_b][35:32] >> psh), rdd_b};
    assign wm_b[35:32] = 4'({B_PD{1'b1}}) << psh;
    assign wd_b[35:32] = 4'(wdata_b[B_W-1:B_DD]) << psh;
  end else begin : g_nopar_b
    assign rd_b = rdd_b;
    assign wm_b[35:32] = '0;
    assign wd_b[35:32] = '0;
  end

  assign nxt_a  = (mem[row_a] & ~wm_a) | (wd_a & wm_a);
  assign base_b = (wr_a && row_a == row_b) ? nxt_a : mem[row_b];
  assign nxt_b  = (base_b & ~wm_b) | (wd_b & wm_b);

  always_ff @(posedge clk) begin
    if (wr_a) mem[row_a] <= nxt_a;
    if (wr_b) mem[row_b] <= nxt_b;
  end

  always_ff @(posedge clk) begin
    if (en_a) begin
      if (srst_a)                    rdata_a <= A_RST_VAL;
      else if (!we_a || A_MODE == 1) rdata_a <= rd_a;
      else if (A_MODE == 0)          rdata_a <= wdata_a;
    end
  end

  always_ff @(posedge clk) begin
    if (en_b) begin
      if (srst_b)                    rdata_b <= B_RST_VAL;
      else if (!we_b || B_MODE == 1) rdata_b <= rd_b;
      else if (B_MODE == 0)          rdata_b <= wdata_b;
    end
  end
endmodule

module dual_aspect_ram_chk #(
  parameter int A_W = 18,
  parameter int B_W = 9,
  parameter int A_MODE = 0,
  parameter int B_MODE = 1,
  parameter logic [A_W-1:0] A_RST_VAL = '0,
  parameter logic [B_W-1:0] B_RST_VAL = '0
) (
  input logic           clk,
  input logic           en_a,
  input logic           we_a,
  input logic           srst_a,
  input logic [A_W-1:0] wdata_a,
  input logic [A_W-1:0] rdata_a,
  input logic           en_b,
  input logic           we_b,
  input logic           srst_b,
  input logic [B_W-1:0] wdata_b,
  input logic [B_W-1:0] rdata_b
);
  logic arm_a = 1'b0;
  logic arm_b = 1'b0;
  always_ff @(posedge clk) begin
    if (en_a && srst_a) arm_a <= 1'b1;
    if (en_b && srst_b) arm_b <= 1'b1;
  end

  a_r7_reset_a: assert property (@(posedge clk) disable iff (!arm_a)
    (en_a && srst_a) |=> (rdata_a == A_RST_VAL));
  a_r7_reset_b: assert property (@(posedge clk) disable iff (!arm_b)
    (en_b && srst_b) |=> (rdata_b == B_RST_VAL));
  a_r8_hold_a: assert property (@(posedge clk) disable iff (!arm_a)
    !en_a |=> $stable(rdata_a));
  a_r8_hold_b: assert property (@(posedge clk) disable iff (!arm_b)
    !en_b |=> $stable(rdata_b));
  a_r4_newdata_a: assert property (@(posedge clk) disable iff (!arm_a)
    (A_MODE == 0 && en_a && we_a && !srst_a) |=> (rdata_a == $past(wdata_a)));
  a_r4_newdata_b: assert property (@(posedge clk) disable iff (!arm_b)
    (B_MODE == 0 && en_b && we_b && !srst_b) |=> (rdata_b == $past(wdata_b)));
  a_r6_keep_a: assert property (@(posedge clk) disable iff (!arm_a)
    (A_MODE == 2 && en_a && we_a && !srst_a) |=> $stable(rdata_a));
  a_r6_keep_b: assert property (@(posedge clk) disable iff (!arm_b)
    (B_MODE == 2 && en_b && we_b && !srst_b) |=> $stable(rdata_b));
endmodule

bind dual_aspect_ram dual_aspect_ram_chk #(
  .A_W(A_W), .B_W(B_W), .A_MODE(A_MODE), .B_MODE(B_MODE),
  .A_RST_VAL(A_RST_VAL), .B_RST_VAL(B_RST_VAL)
) u_chk (
  .clk(clk), .en_a(en_a), .we_a(we_a), .srst_a(srst_a), .wdata_a(wdata_a),
  .rdata_a(rdata_a), .en_b(en_b), .we_b(we_b), .srst_b(srst_b),
  .wdata_b(wdata_b), .rdata_b(rdata_b)
);

// File: tb/dual_aspect_ram_tb.sv
module dual_aspect_ram_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;

  logic        ea = 0, wa = 0, sa = 0, eb = 0, wb = 0, sb = 0;
  logic [9:0]  aa = '0;
  logic [17:0] da = '0, qa;
  logic [10:0] ab = '0;
  logic [8:0]  db = '0, qb;

  dual_aspect_ram #(.A_W(18), .B_W(9), .A_MODE(0), .B_MODE(1),
    .A_RST_VAL(18'h2BEEF), .B_RST_VAL(9'h1A5)) u_dut (
    .clk(clk), .en_a(ea), .we_a(wa), .srst_a(sa), .addr_a(aa), .wdata_a(da),
    .rdata_a(qa), .en_b(eb), .we_b(wb), .srst_b(sb), .addr_b(ab),
    .wdata_b(db), .rdata_b(qb));

  logic        nea = 0, nwa = 0, nsa = 0, neb = 0, nwb = 0, nsb = 0;
  logic [11:0] naa = '0;
  logic [3:0]  nda = '0, nqa;
  logic [8:0]  nab = '0;
  logic [35:0] ndb = '0, nqb;

  dual_aspect_ram #(.A_W(4), .B_W(36), .A_MODE(2), .B_MODE(0),
    .A_RST_VAL(4'h9), .B_RST_VAL(36'h0)) u_nc (
    .clk(clk), .en_a(nea), .we_a(nwa), .srst_a(nsa), .addr_a(naa), .wdata_a(nda),
    .rdata_a(nqa), .en_b(neb), .we_b(nwb), .srst_b(nsb), .addr_b(nab),
    .wdata_b(ndb), .rdata_b(nqb));

  typedef struct packed {
    logic ea, wa, sa; logic [9:0] aa; logic [17:0] da;
    logic eb, wb, sb; logic [10:0] ab; logic [8:0] db;
    logic ca; logic [17:0] xa; logic cb; logic [8:0] xb;
  } vec_t;

  // A: 18-bit {par[1:0],data[15:0]}; B: 9-bit {par,data[7:0]}; A addr n = B addrs 2n,2n+1
  localparam vec_t TBL [10] = '{
    '{1,1,0,10'd5,18'h12345, 0,0,0,11'd0,9'h000,   1,18'h12345, 1,9'h1A5},
    '{0,0,0,10'd0,18'h00000, 1,0,0,11'd10,9'h000,  1,18'h12345, 1,9'h145},
    '{1,0,0,10'd5,18'h00000, 1,1,0,11'd11,9'h1C3,  1,18'h12345, 1,9'h023},
    '{1,0,0,10'd5,18'h00000, 1,0,0,11'd10,9'h000,  1,18'h3C345, 1,9'h145},
    '{0,1,0,10'd5,18'h00000, 1,0,0,11'd11,9'h000,  1,18'h3C345, 1,9'h1C3},
    '{1,0,0,10'd5,18'h00000, 0,0,0,11'd0,9'h000,   1,18'h3C345, 1,9'h1C3},
    '{1,1,1,10'd6,18'h0ABCD, 0,0,1,11'd0,9'h000,   1,18'h2BEEF, 1,9'h1C3},
    '{1,0,0,10'd6,18'h00000, 1,0,0,11'd12,9'h000,  1,18'h0ABCD, 1,9'h0CD},
    '{1,1,0,10'h003,18'h30F0F, 1,1,0,11'h406,9'h055, 1,18'h30F0F, 0,9'h000},
    '{1,0,0,10'h003,18'h00000, 1,0,0,11'h406,9'h000, 1,18'h30F0F, 1,9'h055}
  };
  localparam string TAG [10] = '{
    "R4 R8 new-data write, B idle", "R2 R3 R8 narrow read of wide write",
    "R5 R9 old-data write vs cross read", "R1 R2 R9 merged word with parity",
    "R8 disabled write", "R8 disabled write not stored",
    "R7 R8 reset with write, B reset ignored", "R7 write under reset stored",
    "R10 R4 split halves write", "R10 split halves readback"
  };

  task automatic chk(string tag, logic [35:0] got, logic [35:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    ea = 1; sa = 1; eb = 1; sb = 1;
    @(posedge clk); #1;
    chk("R7 reset value port A", 36'(qa), 36'h2BEEF);
    chk("R7 reset value port B", 36'(qb), 36'h1A5);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ea = TBL[i].ea; wa = TBL[i].wa; sa = TBL[i].sa; aa = TBL[i].aa; da = TBL[i].da;
      eb = TBL[i].eb; wb = TBL[i].wb; sb = TBL[i].sb; ab = TBL[i].ab; db = TBL[i].db;
      @(posedge clk); #1;
      if (TBL[i].ca) chk({TAG[i], " port A"}, 36'(qa), 36'(TBL[i].xa));
      if (TBL[i].cb) chk({TAG[i], " port B"}, 36'(qb), 36'(TBL[i].xb));
    end
    @(negedge clk);
    ea = 0; wa = 0; eb = 0; wb = 0;

    // second instance: A 4-bit hold mode, B 36-bit new-data mode
    nea = 1; nsa = 1; neb = 1; nsb = 1;
    @(posedge clk); #1;
    chk("R7 reset nibble port", 36'(nqa), 36'h9);
    chk("R7 reset wide port", nqb, 36'h0);
    @(negedge clk);
    nea = 0; nsa = 0; nsb = 0; nwb = 1; nab = 9'd0; ndb = 36'h0_1234_5678;
    @(posedge clk); #1;
    chk("R4 wide write shows new word", nqb, 36'h0_1234_5678);
    chk("R8 nibble port held while disabled", 36'(nqa), 36'h9);
    @(negedge clk);
    nwb = 0; neb = 0; nea = 1; naa = 12'd1;
    @(posedge clk); #1;
    chk("R2 nibble 1 of row 0", 36'(nqa), 36'h7);
    @(negedge clk);
    nwa = 1; nda = 4'hE;
    @(posedge clk); #1;
    chk("R6 hold mode keeps output on write", 36'(nqa), 36'h7);
    @(negedge clk);
    nwa = 0; naa = 12'd2; neb = 1; nab = 9'd0;
    @(posedge clk); #1;
    chk("R6 hold-mode write stored", nqb, 36'h0_1234_56E8);
    chk("R2 nibble 2 of row 0", 36'(nqa), 36'h6);
    @(negedge clk);
    nea = 0; neb = 0;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired: got=running exp=done");
    finish_run();
  end
endmodule